// File: doc/BRIEF.md
# Interval Timer with Modulo Reload

This block is a small memory-mapped timer for a processor subsystem running from a 4.194304 MHz system clock. A 16-bit prescaler counts every clock cycle, and its upper byte can be read as a free-running divider. An 8-bit up-counter advances on ticks taken from the prescaler at one of four rates. A 2-bit rate code picks the rate and an enable bit gates the counting.

When the counter passes 0xFF it does not wrap to zero. It reloads from a software-programmed modulo register, so software sets the interrupt period by choosing the modulo value. In the cycle that shows the reloaded value, the block raises a one-cycle interrupt request pulse for an external interrupt controller. Software reaches all four registers through a simple bus: address, write data, write strobe and combinational read data.

Top module: `interval_timer`

## Requirements
- R1: After reset the divider, counter, modulo and control registers all read 0x00, and the interrupt output is low.
- R2: The counter (address 1) and modulo (address 2) registers read back the value last written. The control register (address 3) keeps write-data bits 2:0 and reads 0 in bits 7:3.
- R3: The divider (address 0) reads the upper 8 bits of a 16-bit count that increases by one every clock cycle. It therefore reads N when 256·N to 256·N+255 cycles have passed since the count was last cleared.
- R4: A write to the divider address clears the whole 16-bit count to zero, whatever the write data. This also restarts the phase of the counter ticks.
- R5: While control bit 2 is 0, the counter holds its value and no interrupt is raised.
- R6: While control bit 2 is 1, the counter advances once every D cycles. D is 1024, 16, 64 or 256 for control bits 1:0 equal to 00, 01, 10 or 11. A tick falls on the clock edge where the low log2(D) bits of the 16-bit count are all ones. With the count cleared at edge 0, the first tick is at edge D.
- R7: A tick that finds the counter at 0xFF loads the counter from the modulo register. It also drives the interrupt output high for exactly one cycle, the same cycle in which the counter first shows the reloaded value.
- R8: A bus write to the counter in the same cycle as a tick wins. The counter takes the written value, does not increment, and raises no interrupt.
- R9: An overflow reloads the modulo value held before that clock edge. A modulo write in the same cycle takes effect only for later reloads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | ADDR_W | Register address: 0 divider, 1 counter, 2 modulo, 3 control |
| busWrData | input | DATA_W | Write data |
| busWe | input | 1 | Write strobe, one write per cycle |
| busRdData | output | DATA_W | Read data for busAddr (combinational) |
| irqPulse | output | 1 | One-cycle interrupt request on counter reload |

## Verification
The hardest cases to reach are the same-cycle collisions: a counter or modulo write on exactly the edge where a tick overflows the counter. The tick phase is hidden inside the prescaler. The bench first makes it known by writing the divider, which clears the count at a chosen edge. It then counts edges from that point to place the colliding write on edge 16 at the fastest rate. The same alignment gives exact edge counts for the first and second tick of every rate code and for the overflow pulse.

// File: rtl/timer_pkg.sv
package timer_pkg;

  // Register addresses; software-visible map
  localparam logic [1:0] ADDR_DIV = 2'd0;
  localparam logic [1:0] ADDR_CNT = 2'd1;
  localparam logic [1:0] ADDR_MOD = 2'd2;
  localparam logic [1:0] ADDR_CTL = 2'd3;

  // Control register layout: [2] enable, [1:0] rate code
  localparam int CTL_W  = 3;
  localparam int EN_BIT = 2;
  localparam int NUM_RATES = 4;

  // Strobes from control to datapath
  typedef struct packed {
    logic wrDiv;
    logic wrCnt;
    logic wrMod;
    logic wrCtl;
    logic tick;
  } tmr_strobe_t;

  // log2 of the prescaler divisor for each rate code (non-monotonic order)
  function automatic int rateShift(input logic [1:0] code);
    case (code)
      2'b00:   return 10;
      2'b01:   return 4;
      2'b10:   return 6;
      default: return 8;
    endcase
  endfunction

endpackage

// File: rtl/timer_ctrl.sv
module timer_ctrl
  import timer_pkg::*;
#(
  parameter int PRE_W  = 16,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [CTL_W-1:0]  ctlWrData,
  output tmr_strobe_t       strobe,
  output logic [CTL_W-1:0]  ctlQ,
  output logic [DATA_W-1:0] divHi
);

  logic [PRE_W-1:0]     preQ;
  logic [NUM_RATES-1:0] rateHit;
  logic                 wrDiv, wrCnt, wrMod, wrCtl;

  // Address decode
  assign wrDiv = busWe && (busAddr == ADDR_W'(ADDR_DIV));
  assign wrCnt = busWe && (busAddr == ADDR_W'(ADDR_CNT));
  assign wrMod = busWe && (busAddr == ADDR_W'(ADDR_MOD));
  assign wrCtl = busWe && (busAddr == ADDR_W'(ADDR_CTL));

  // Free-running prescaler, cleared by any divider write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      preQ <= '0;
    else if (wrDiv) preQ <= '0;
    else            preQ <= preQ + 1'b1;
  end

  // Control register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      ctlQ <= '0;
    else if (wrCtl) ctlQ <= ctlWrData;
  end

  // One tick detector per rate code
  for (genvar c = 0; c < NUM_RATES; c++) begin : g_rate
    localparam int SH = rateShift(2'(c));
    assign rateHit[c] = &preQ[SH-1:0];
  end

  assign divHi = preQ[PRE_W-1 -: DATA_W];

  always_comb begin
    strobe.wrDiv = wrDiv;
    strobe.wrCnt = wrCnt;
    strobe.wrMod = wrMod;
    strobe.wrCtl = wrCtl;
    strobe.tick  = ctlQ[EN_BIT] && rateHit[ctlQ[1:0]];
  end

endmodule

// File: rtl/timer_datapath.sv
module timer_datapath
  import timer_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  tmr_strobe_t       strobe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  input  logic [CTL_W-1:0]  ctlQ,
  input  logic [DATA_W-1:0] divHi,
  output logic [DATA_W-1:0] cntQ,
  output logic [DATA_W-1:0] modQ,
  output logic              irqQ,
  output logic [DATA_W-1:0] busRdData
);

  localparam logic [DATA_W-1:0] CNT_MAX = '1;

  logic atMax;
  logic overflow;

  assign atMax    = (cntQ == CNT_MAX);
  assign overflow = strobe.tick && atMax && !strobe.wrCnt;

  // Counter: bus write beats tick, overflow reloads from modulo
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              cntQ <= '0;
    else if (strobe.wrCnt)  cntQ <= busWrData;
    else if (strobe.tick) begin
      if (atMax) cntQ <= modQ;
      else       cntQ <= cntQ + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             modQ <= '0;
    else if (strobe.wrMod) modQ <= busWrData;
  end

  // Interrupt pulse registered alongside the reload
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqQ <= 1'b0;
    else       irqQ <= overflow;
  end

  // Read-back mux
  always_comb begin
    busRdData = '0;
    case (busAddr)
      ADDR_W'(ADDR_DIV): busRdData = divHi;
      ADDR_W'(ADDR_CNT): busRdData = cntQ;
      ADDR_W'(ADDR_MOD): busRdData = modQ;
      ADDR_W'(ADDR_CTL): busRdData = DATA_W'(ctlQ);
      default:           busRdData = '0;
    endcase
  end

endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import timer_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PRE_W  = 16,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              busWe,
  output logic [DATA_W-1:0] busRdData,
  output logic              irqPulse
);

  tmr_strobe_t       strobe;
  logic [CTL_W-1:0]  ctlQ;
  logic [DATA_W-1:0] divHi;
  logic [DATA_W-1:0] cntQ;
  logic [DATA_W-1:0] modQ;

  timer_ctrl #(
    .PRE_W (PRE_W),
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W)
  ) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busAddr  (busAddr),
    .busWe    (busWe),
    .ctlWrData(busWrData[CTL_W-1:0]),
    .strobe   (strobe),
    .ctlQ     (ctlQ),
    .divHi    (divHi)
  );

  timer_datapath #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W)
  ) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .busAddr  (busAddr),
    .busWrData(busWrData),
    .ctlQ     (ctlQ),
    .divHi    (divHi),
    .cntQ     (cntQ),
    .modQ     (modQ),
    .irqQ     (irqPulse),
    .busRdData(busRdData)
  );

endmodule

// File: rtl/timer_checker.sv
module timer_checker
  import timer_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWrData,
  input logic              busWe,
  input logic              irqPulse,
  input logic [DATA_W-1:0] cntQ,
  input logic [DATA_W-1:0] modQ,
  input logic [CTL_W-1:0]  ctlQ,
  input logic [DATA_W-1:0] divHi
);

  logic cntWrite, divWrite;
  assign cntWrite = busWe && (busAddr == ADDR_W'(ADDR_CNT));
  assign divWrite = busWe && (busAddr == ADDR_W'(ADDR_DIV));

  // R7: interrupt lasts one cycle only
  assert_irq_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |=> !irqPulse);

  // R9: pulse coincides with counter holding the pre-edge modulo value
  assert_reload_value_R9: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> (cntQ == $past(modQ)));

  // R5: disabled counter holds unless written
  assert_hold_stopped_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!ctlQ[EN_BIT] && !cntWrite) |=> $stable(cntQ));

  // R5: no interrupt while disabled
  assert_no_irq_stopped_R5: assert property (@(posedge clk) disable iff (!rstN)
    !ctlQ[EN_BIT] |=> !irqPulse);

  // R4: divider write clears the visible divider
  assert_div_clear_R4: assert property (@(posedge clk) disable iff (!rstN)
    divWrite |=> (divHi == '0));

  // R8: counter write wins and suppresses the interrupt
  assert_write_wins_R8: assert property (@(posedge clk) disable iff (!rstN)
    cntWrite |=> ((cntQ == $past(busWrData)) && !irqPulse));

endmodule

bind interval_timer timer_checker #(
  .DATA_W(DATA_W),
  .ADDR_W(ADDR_W)
) u_timerChecker (
  .clk      (clk),
  .rstN     (rstN),
  .busAddr  (busAddr),
  .busWrData(busWrData),
  .busWe    (busWe),
  .irqPulse (irqPulse),
  .cntQ     (cntQ),
  .modQ     (modQ),
  .ctlQ     (ctlQ),
  .divHi    (divHi)
);

// File: tb/test_interval_timer.sv
`timescale 1ns/1ps
module test_interval_timer;

  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [DATA_W-1:0] busWrData = '0;
  logic              busWe = 1'b0;
  logic [DATA_W-1:0] busRdData;
  logic              irqPulse;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  interval_timer #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_interval_timer (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrData(busWrData),
    .busWe(busWe), .busRdData(busRdData), .irqPulse(irqPulse)
  );

  task automatic expect8(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // Write: driven at a negedge, taken at the next posedge, returns at the negedge after
  task automatic writeReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  // Read: combinational, consumes no edge
  task automatic readReg(input logic [1:0] a, output logic [7:0] d);
    busAddr = a;
    #1;
    d = busRdData;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    for (int a = 0; a < 4; a++) begin
      readReg(2'(a), v);
      expect8("R1 register", v, 8'h00);
    end
    expect8("R1 irq", {7'd0, irqPulse}, 8'h00);
  endtask

  task automatic t_readback;
    logic [7:0] v;
    writeReg(2'd1, 8'h5A);
    writeReg(2'd2, 8'hC3);
    writeReg(2'd3, 8'hFB);
    readReg(2'd1, v); expect8("R2 counter", v, 8'h5A);
    readReg(2'd2, v); expect8("R2 modulo", v, 8'hC3);
    readReg(2'd3, v); expect8("R2 control", v, 8'h03);
    writeReg(2'd3, 8'h00);
  endtask

  task automatic t_divider;
    logic [7:0] v;
    writeReg(2'd0, 8'hAB);
    readReg(2'd0, v); expect8("R4 cleared", v, 8'h00);
    repeat (255) @(negedge clk);
    readReg(2'd0, v); expect8("R3 at 255", v, 8'h00);
    @(negedge clk);
    readReg(2'd0, v); expect8("R3 at 256", v, 8'h01);
    repeat (256) @(negedge clk);
    readReg(2'd0, v); expect8("R3 at 512", v, 8'h02);
    writeReg(2'd0, 8'h00);
    readReg(2'd0, v); expect8("R4 rewrite", v, 8'h00);
  endtask

  task automatic t_stopped;
    logic [7:0] v;
    logic seen = 1'b0;
    writeReg(2'd3, 8'h01);
    writeReg(2'd1, 8'hFF);
    repeat (100) begin
      @(negedge clk);
      seen |= irqPulse;
    end
    readReg(2'd1, v); expect8("R5 held", v, 8'hFF);
    expect8("R5 no irq", {7'd0, seen}, 8'h00);
  endtask

  // Leaves time right after edge E2 relative to a divider clear at E0
  task automatic armTimer(input logic [1:0] code, input logic [7:0] cnt, input logic [7:0] modv);
    writeReg(2'd3, 8'h00);
    writeReg(2'd2, modv);
    writeReg(2'd1, cnt);
    writeReg(2'd0, 8'h00);
    writeReg(2'd3, {5'd0, 1'b1, code});
  endtask

  task automatic t_rate(input logic [1:0] code, input int d);
    logic [7:0] v;
    armTimer(code, 8'h00, 8'h00);
    repeat (d - 3) @(negedge clk);
    readReg(2'd1, v); expect8($sformatf("R6 code %0d before tick", code), v, 8'h00);
    @(negedge clk);
    readReg(2'd1, v); expect8($sformatf("R6 code %0d first tick", code), v, 8'h01);
    repeat (d - 1) @(negedge clk);
    readReg(2'd1, v); expect8($sformatf("R6 code %0d before second", code), v, 8'h01);
    @(negedge clk);
    readReg(2'd1, v); expect8($sformatf("R6 code %0d second tick", code), v, 8'h02);
    writeReg(2'd3, 8'h00);
  endtask

  task automatic t_overflow;
    logic [7:0] v;
    logic early = 1'b0;
    armTimer(2'b01, 8'hFE, 8'hF0);
    repeat (29) begin
      @(negedge clk);
      early |= irqPulse;
    end
    expect8("R7 no early irq", {7'd0, early}, 8'h00);
    @(negedge clk);
    readReg(2'd1, v); expect8("R7 reload value", v, 8'hF0);
    expect8("R7 irq with reload", {7'd0, irqPulse}, 8'h01);
    @(negedge clk);
    expect8("R7 irq one cycle", {7'd0, irqPulse}, 8'h00);
    writeReg(2'd3, 8'h00);
  endtask

  task automatic t_write_collide;
    logic [7:0] v;
    armTimer(2'b01, 8'hFF, 8'h20);
    repeat (12) @(negedge clk);
    writeReg(2'd1, 8'h77);
    readReg(2'd1, v); expect8("R8 write wins", v, 8'h77);
    expect8("R8 no irq", {7'd0, irqPulse}, 8'h00);
    repeat (15) @(negedge clk);
    readReg(2'd1, v); expect8("R8 before next tick", v, 8'h77);
    @(negedge clk);
    readReg(2'd1, v); expect8("R8 next tick", v, 8'h78);
    writeReg(2'd3, 8'h00);
  endtask

  task automatic t_mod_collide;
    logic [7:0] v;
    armTimer(2'b01, 8'hFF, 8'h40);
    repeat (12) @(negedge clk);
    writeReg(2'd2, 8'h99);
    readReg(2'd1, v); expect8("R9 old modulo used", v, 8'h40);
    expect8("R9 irq", {7'd0, irqPulse}, 8'h01);
    readReg(2'd2, v); expect8("R9 new modulo stored", v, 8'h99);
    writeReg(2'd3, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_readback();
    t_divider();
    t_stopped();
    t_rate(2'b00, 1024);
    t_rate(2'b01, 16);
    t_rate(2'b10, 64);
    t_rate(2'b11, 256);
    t_overflow();
    t_write_collide();
    t_mod_collide();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule